// File: doc/BRIEF.md
# Two-Stage UART Oversampling Tick Generator

This block produces the 16x oversampling enable that paces a UART transmitter and receiver. The enable comes from one of two sources. The internal source is made from the system clock by a programmable pre-divider. The external source is a free-running serial clock pin: it is synchronised into the system domain, and each of its rising edges counts as one source tick.

A 16-bit baud divisor then counts source ticks. For every divisor-many ticks it emits one enable pulse that lasts one system cycle. The output is a clock enable and not a derived clock, so all downstream logic stays on the system clock.

The settings are plain level inputs, held by whatever register bank owns them. When the block sees a new pre-divider value, a new divisor or a new source select, it restarts the affected count from zero. The new rate therefore applies from the next full count and never from a half-finished one.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, tick16_o is low.
- R2: With src_sel_i = 0 and a pre-divider value P in 1..255, the internal source ticks once every P system cycles. With P = 0 the internal source never ticks.
- R3: With a divisor D in 1..65535, tick16_o pulses once for every D source ticks. It pulses in the cycle after the source tick that completes the count, and it stays high for exactly one system cycle for each completed count.
- R4: With a divisor of 0, tick16_o stays low whatever the source does.
- R5: src_sel_i = 0 selects the internal pre-divided source. src_sel_i = 1 selects the external clock, and the internal source then has no effect on the output.
- R6: Each rising edge of ext_clk_i becomes one source tick after a two-flop synchroniser and an edge-detect register. A rising edge that ext_clk_i shows at clock edge k yields its source tick at edge k+2. Holding ext_clk_i high or low produces no ticks.
- R7: In the cycle where a new divisor value is first seen, no pulse is produced. The divisor count restarts from zero, so the next pulse follows D full source ticks at the new value.
- R8: A change of the pre-divider value restarts the internal count. The next internal tick follows P full cycles at the new value.
- R9: A change of src_sel_i clears the divisor count and suppresses any pulse in the cycle where the change is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External serial clock, asynchronous to clk |
| src_sel_i | input | 1 | Source select: 0 internal, 1 external |
| prediv_i | input | 8 | Pre-divider value for the internal source (0 = off) |
| divisor_i | input | 16 | Baud divisor (0 = no output) |
| tick16_o | output | 1 | One-cycle 16x oversampling enable |

## Verification
A wrong divisor or pre-divider count shows at the port as a pulse that comes early or late. The error is visible at the first pulse after the fault, within one full period of D times the source spacing. A stale reload after a settings change shows in the same way, as a first pulse at the wrong distance from the change. A broken synchroniser or edge detector shifts every external-driven pulse by a cycle, or it doubles or drops ticks, and the cycle-exact model catches this at the next pulse. A divisor of zero, a pre-divider of zero or a steady external level that still yields output fails at the first spurious pulse.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned PRE_W_DEF = 8;
  localparam int unsigned DIV_W_DEF = 16;

  // True when a count has reached the last step of a non-zero limit.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim - 32'd1);
  endfunction

  // Next value of a modulo-lim counter advanced by one step.
  function automatic logic [31:0] step_count(input logic [31:0] cnt, input logic [31:0] lim);
    if (at_limit(cnt, lim)) return 32'd0;
    return cnt + 32'd1;
  endfunction
endpackage

// File: rtl/bt_prediv.sv
module bt_prediv #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_i,
  output logic         tick_o,
  output logic         zero_o,
  output logic         reload_o
);
  logic [W-1:0] lim_q;
  logic [W-1:0] cnt_q;
  logic         last;

  assign reload_o = (div_i != lim_q);
  assign zero_o   = (lim_q == '0);
  assign last     = bt_pkg::at_limit(32'(cnt_q), 32'(lim_q));
  assign tick_o   = !reload_o && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (reload_o) begin
      lim_q <= div_i;
      cnt_q <= '0;
    end else if (!zero_o) begin
      cnt_q <= W'(bt_pkg::step_count(32'(cnt_q), 32'(lim_q)));
    end
  end
endmodule

// File: rtl/bt_ext_sync.sv
module bt_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] && !hist_q;
endmodule

// File: rtl/bt_baud_div.sv
module bt_baud_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_tick_i,
  input  logic         sel_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o,
  output logic         fire_o,
  output logic         zero_o,
  output logic         reload_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] lim_o
);
  logic [W-1:0] lim_q;
  logic [W-1:0] cnt_q;
  logic         sel_q;
  logic         out_q;

  assign reload_o = (div_i != lim_q) || (sel_i != sel_q);
  assign zero_o   = (lim_q == '0);
  assign fire_o   = !reload_o && src_tick_i &&
                    bt_pkg::at_limit(32'(cnt_q), 32'(lim_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
      sel_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      out_q <= fire_o;
      if (reload_o) begin
        lim_q <= div_i;
        sel_q <= sel_i;
        cnt_q <= '0;
      end else if (src_tick_i && !zero_o) begin
        cnt_q <= W'(bt_pkg::step_count(32'(cnt_q), 32'(lim_q)));
      end
    end
  end

  assign tick_o = out_q;
  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned PRE_W       = bt_pkg::PRE_W_DEF,
  parameter int unsigned DIV_W       = bt_pkg::DIV_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             src_sel_i,
  input  logic [PRE_W-1:0] prediv_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick16_o
);
  logic             int_tick;
  logic             pre_zero;
  logic             pre_reload;
  logic             ext_tick;
  logic             src_tick;
  logic             baud_fire;
  logic             div_zero;
  logic             div_reload;
  logic [DIV_W-1:0] baud_cnt;
  logic [DIV_W-1:0] baud_lim;

  bt_prediv #(.W(PRE_W)) u_prediv (
    .clk(clk), .rst_n(rst_n), .div_i(prediv_i),
    .tick_o(int_tick), .zero_o(pre_zero), .reload_o(pre_reload)
  );

  bt_ext_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .rise_o(ext_tick)
  );

  assign src_tick = src_sel_i ? ext_tick : int_tick;

  bt_baud_div #(.W(DIV_W)) u_baud_div (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick), .sel_i(src_sel_i),
    .div_i(divisor_i), .tick_o(tick16_o), .fire_o(baud_fire),
    .zero_o(div_zero), .reload_o(div_reload),
    .cnt_o(baud_cnt), .lim_o(baud_lim)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_sel_i,
  input logic [DIV_W-1:0] divisor_i,
  input logic             tick16_o,
  input logic             int_tick,
  input logic             pre_zero,
  input logic             pre_reload,
  input logic             ext_tick,
  input logic             src_tick,
  input logic             div_zero,
  input logic [DIV_W-1:0] baud_cnt,
  input logic [DIV_W-1:0] baud_lim
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  always @(negedge clk) begin
    if (seen_clk && !rst_n) begin
      a_r1_low_in_reset: assert (!tick16_o);
    end
  end

  a_r2_prediv_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_zero && !pre_reload) |-> !int_tick);

  a_r3_pulse_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    tick16_o |-> $past(src_tick));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !div_zero |-> (baud_cnt < baud_lim));

  a_r4_zero_divisor_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero && divisor_i == '0) |=> !tick16_o);

  a_r6_edge_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);

  a_r7_divisor_change_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor_i != $past(divisor_i)) |=> !tick16_o);

  a_r9_select_change_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i != $past(src_sel_i)) |=> !tick16_o);
endmodule

bind baud_tick_gen bt_checker #(.DIV_W(DIV_W)) u_bt_checker (
  .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel_i), .divisor_i(divisor_i),
  .tick16_o(tick16_o), .int_tick(int_tick), .pre_zero(pre_zero),
  .pre_reload(pre_reload), .ext_tick(ext_tick), .src_tick(src_tick),
  .div_zero(div_zero), .baud_cnt(baud_cnt), .baud_lim(baud_lim)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        src_sel_i = 1'b0;
  logic [7:0]  prediv_i = 8'd0;
  logic [15:0] divisor_i = 16'd0;
  logic        tick16_o;

  int n_vec = 0;
  int n_bad = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .src_sel_i(src_sel_i),
    .prediv_i(prediv_i), .divisor_i(divisor_i), .tick16_o(tick16_o)
  );

  // Behavioural reference: ext history queue, integer counters.
  bit ext_hist[$] = '{0, 0, 0};
  int m_plim = 0, m_pcnt = 0;
  int m_dlim = 0, m_dcnt = 0;
  bit m_sel = 0, m_out = 0;
  int pulses = 0;

  always @(posedge clk) begin
    bit itick, etick, stick, dchg;
    if (!rst_n) begin
      ext_hist = '{0, 0, 0};
      m_plim = 0; m_pcnt = 0; m_dlim = 0; m_dcnt = 0; m_sel = 0; m_out = 0;
    end else begin
      itick = (int'(prediv_i) == m_plim) && m_plim != 0 && m_pcnt == m_plim - 1;
      etick = ext_hist[1] && !ext_hist[2];
      stick = src_sel_i ? etick : itick;
      dchg  = (int'(divisor_i) != m_dlim) || (src_sel_i != m_sel);
      m_out = !dchg && stick && m_dlim != 0 && m_dcnt == m_dlim - 1;
      if (int'(prediv_i) != m_plim) begin m_plim = int'(prediv_i); m_pcnt = 0; end
      else if (m_plim != 0) m_pcnt = (m_pcnt + 1) % m_plim;
      if (dchg) begin m_dlim = int'(divisor_i); m_sel = src_sel_i; m_dcnt = 0; end
      else if (stick && m_dlim != 0) m_dcnt = (m_dcnt + 1) % m_dlim;
      ext_hist.push_front(ext_clk_i);
      void'(ext_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    n_vec++;
    if (tick16_o !== m_out) begin
      n_bad++;
      $display("FAIL %s: tick16_o actual %0b expected %0b at %0t", phase, tick16_o, m_out, $time);
    end
    if (tick16_o === 1'b1) pulses++;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulses(input string tag, input int n, input int want);
    int got;
    pulses = 0;
    run(n);
    got = pulses;
    n_vec++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: pulse count actual %0d expected %0d", tag, got, want);
    end
  endtask

  int ext_period = 0;
  always @(negedge clk) begin
    int c;
    if (ext_period > 0) begin
      c = (c + 1) % ext_period;
      ext_clk_i <= (c < ext_period / 2);
    end
  end

  initial begin
    fork
      begin
        phase = "R1";
        run(5);
        rst_n = 1'b1;
        run(3);
        phase = "R2 R3";
        prediv_i = 8'd1; divisor_i = 16'd1;
        run(2);
        expect_pulses("R3 P1 D1", 50, 50);
        prediv_i = 8'd3; divisor_i = 16'd4;
        run(2);
        expect_pulses("R2 P3 D4", 120, 10);
        phase = "R2 zero";
        prediv_i = 8'd0;
        expect_pulses("R2 prediv zero", 200, 0);
        phase = "R4";
        prediv_i = 8'd1; divisor_i = 16'd0;
        expect_pulses("R4 divisor zero", 200, 0);
        phase = "R7";
        divisor_i = 16'd5;
        run(13);
        divisor_i = 16'd7;
        run(20);
        phase = "R8";
        prediv_i = 8'd2;
        run(9);
        prediv_i = 8'd5;
        run(40);
        phase = "R5 R6";
        ext_period = 6; divisor_i = 16'd3;
        run(30);
        src_sel_i = 1'b1;
        run(10);
        expect_pulses("R6 ext D3", 180, 10);
        phase = "R5 ignore internal";
        prediv_i = 8'd1;
        run(50);
        ext_period = 0; ext_clk_i <= 1'b1;
        run(10);
        expect_pulses("R6 steady ext", 100, 0);
        phase = "R9";
        ext_period = 8;
        run(37);
        src_sel_i = 1'b0;
        run(23);
        src_sel_i = 1'b1;
        run(40);
        phase = "R3 max divisor";
        src_sel_i = 1'b0; prediv_i = 8'd1; divisor_i = 16'd65535;
        run(2);
        expect_pulses("R3 D65535", 65535, 1);
        phase = "R1 reset";
        rst_n = 1'b0;
        run(4);
        rst_n = 1'b1;
        run(30);
      end
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule